// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable integer ratio. A dual-modulus prescaler stage counts input cycles in periods of either N or N+1, where N is 32 in the low band and 47 in the high band. Two down-counters advance once per prescaler period: a program counter loaded with P and a swallow counter loaded with S. Each output period is S prescaler periods of N+1 input cycles followed by P-S periods of N cycles, so the whole ratio is N*P+S input cycles.

A controller holds the modulus select (`mod_o`). While it is low, the prescaler uses the long period and the swallow counter steps. When the swallow counter reaches zero, `mod_o` rises and the swallow counter holds its value until the end of the period. When the program counter reaches zero, the reload strobe `ld_o` fires for one input cycle. At the end of that cycle both counters, the band and the modulus are reloaded from the inputs. `div_out` is the divided output: a one-cycle pulse in the cycle after `ld_o`. The band and the P and S values are sampled only at a reload, so they can be changed at any time without disturbing a period in progress.

The controller has three states. `ST_INIT` is entered by reset and lasts one cycle, in which the first configuration is loaded. `ST_SWALLOW` is the long-period phase with `mod_o`=0. `ST_MAIN` is the short-period phase with `mod_o`=1. The transitions are:
- init-to-swallow when S is not zero, and init-to-main when it is;
- swallow-to-main when the swallow counter expires;
- a reload from swallow or main, which goes to `ST_SWALLOW`, or straight to `ST_MAIN` when the new S is zero.

Top module: `swallow_divider`

## Requirements
- R1: With `band_hi`=0 the ratio uses N=32, and with `band_hi`=1 it uses N=47. Consecutive `div_out` pulses are N*P+S input cycles apart for any 1 <= P <= 127 and 0 <= S <= P. This covers P from 75 to 78 with S up to 31 in the low band, and P from 105 to 122 with S up to 47 in the high band.
- R2: In each output period `mod_o` is 0 for the first S*(N+1) input cycles, counted from the `div_out` cycle, and 1 for the rest. `mod_o` rises only at the end of a prescaler period or of the init cycle.
- R3: When S=0, `mod_o` is 1 for the whole output period, so every prescaler period is N cycles long.
- R4: After `mod_o` rises, the swallow counter holds its value. `mod_o` returns to 0 only at a reload, never in the middle of a period.
- R5: `ld_o` is high for exactly one input cycle per output period, in the last cycle of that period. `div_out` is high for exactly one cycle, in the cycle after `ld_o`.
- R6: `band_hi`, `p_load` and `s_load` are sampled only in the `ld_o` cycle or the init cycle. Changing them in the middle of a period leaves that period's length unchanged, and the next period uses the new values.
- R7: While `rst_n` is low, `div_out`, `ld_o` and `mod_o` are all 0. The first rising edge after reset release loads the configuration. The first `ld_o` then appears N*P+S-1 cycles after the first cycle of the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| band_hi | input | 1 | Band select: 0 gives N=32, 1 gives N=47 |
| p_load | input | 7 | Program count P, at least 1 |
| s_load | input | 6 | Swallow count S, at most P |
| div_out | output | 1 | Divided output, a one-cycle pulse per period |
| mod_o | output | 1 | Modulus select: 0 for the N+1 period, 1 for the N period |
| ld_o | output | 1 | Reload strobe, high in the last cycle of each period |

## Verification
The bound checker watches, on every cycle:
- that prescaler periods are never shorter than 32 cycles;
- that `mod_o` rises only at a prescaler period end or at init, and falls only with `ld_o`;
- that `ld_o` is followed by exactly one cycle of `div_out`;
- that all outputs stay quiet during reset.

The exact ratio N*P+S and the length of the swallow phase, S*(N+1), can only be shown by the bench's scenarios. So can the rule that a mid-period change of band, P or S waits for the next reload. The bench sweeps both bands over their P ranges and several S values, including 0, 1, the band maximum and S=P.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

    typedef enum logic [1:0] {
        ST_INIT    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } sw_state_t;

endpackage

// File: rtl/swdiv_downcnt.sv
module swdiv_downcnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic         cnt_last
);

    logic [W-1:0] cnt_q;

    // reload has priority over a step in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (step)
            cnt_q <= cnt_q - 1'b1;
    end

    // the step taken while the count is one brings it to zero
    assign cnt_last = (cnt_q == W'(1));

endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
    parameter int N_LO = 32,
    parameter int N_HI = 47
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic band_nx,
    input  logic mod_nx,
    output logic tick
);

    localparam int CW = $clog2(N_HI + 1);
    localparam logic [CW-1:0] LO_LONG  = CW'(N_LO);
    localparam logic [CW-1:0] LO_SHORT = CW'(N_LO - 1);
    localparam logic [CW-1:0] HI_LONG  = CW'(N_HI);
    localparam logic [CW-1:0] HI_SHORT = CW'(N_HI - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] start_val;

    // period length minus one for the next period, picked by band and modulus
    always_comb begin
        unique case ({band_nx, mod_nx})
            2'b00:   start_val = LO_LONG;
            2'b01:   start_val = LO_SHORT;
            2'b10:   start_val = HI_LONG;
            default: start_val = HI_SHORT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || tick)
            cnt_q <= start_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/swdiv_fsm.sv
module swdiv_fsm
    import swdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      p_last,
    input  logic      s_last,
    input  logic      s_zero,
    input  logic      band_in,
    output sw_state_t state,
    output logic      init,
    output logic      ld,
    output logic      reload,
    output logic      mod,
    output logic      mod_nx,
    output logic      band_nx,
    output logic      s_step
);

    sw_state_t state_nx;
    sw_state_t reload_target;
    logic      band_q;

    // state register, plus the band held for the running period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_INIT;
            band_q <= 1'b0;
        end else begin
            state  <= state_nx;
            band_q <= band_nx;
        end
    end

    // transitions
    always_comb begin
        reload_target = s_zero ? ST_MAIN : ST_SWALLOW;
        state_nx      = state;
        unique case (state)
            ST_INIT:    state_nx = reload_target;
            ST_SWALLOW: begin
                if (tick && p_last)
                    state_nx = reload_target;
                else if (tick && s_last)
                    state_nx = ST_MAIN;
            end
            ST_MAIN: begin
                if (tick && p_last)
                    state_nx = reload_target;
            end
            default:    state_nx = ST_INIT;
        endcase
    end

    // outputs
    always_comb begin
        init    = (state == ST_INIT);
        ld      = (state != ST_INIT) && tick && p_last;
        reload  = init || ld;
        mod     = (state == ST_MAIN);
        mod_nx  = (state_nx == ST_MAIN);
        band_nx = reload ? band_in : band_q;
        s_step  = tick && (state == ST_SWALLOW);
    end

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swdiv_pkg::*;
#(
    parameter int P_W  = 7,
    parameter int S_W  = 6,
    parameter int N_LO = 32,
    parameter int N_HI = 47
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic           band_hi,
    input  logic [P_W-1:0] p_load,
    input  logic [S_W-1:0] s_load,
    output logic           div_out,
    output logic           mod_o,
    output logic           ld_o
);

    sw_state_t state;
    logic      tick;
    logic      init;
    logic      reload;
    logic      mod_nx;
    logic      band_nx;
    logic      s_step;
    logic      p_last;
    logic      s_last;
    logic      s_zero;
    logic      div_q;

    assign s_zero = (s_load == '0);

    swdiv_fsm u_fsm (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .tick    (tick),
        .p_last  (p_last),
        .s_last  (s_last),
        .s_zero  (s_zero),
        .band_in (band_hi),
        .state   (state),
        .init    (init),
        .ld      (ld_o),
        .reload  (reload),
        .mod     (mod_o),
        .mod_nx  (mod_nx),
        .band_nx (band_nx),
        .s_step  (s_step)
    );

    swdiv_prescaler #(
        .N_LO (N_LO),
        .N_HI (N_HI)
    ) u_presc (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .run     (!init),
        .restart (init),
        .band_nx (band_nx),
        .mod_nx  (mod_nx),
        .tick    (tick)
    );

    swdiv_downcnt #(.W(P_W)) u_pcnt (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (p_load),
        .step     (tick),
        .cnt_last (p_last)
    );

    swdiv_downcnt #(.W(S_W)) u_scnt (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (s_load),
        .step     (s_step),
        .cnt_last (s_last)
    );

    // divided output: one cycle, following the reload strobe
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n)
            div_q <= 1'b0;
        else
            div_q <= ld_o;
    end

    assign div_out = div_q;

endmodule

// File: rtl/swdiv_chk.sv
module swdiv_chk #(
    parameter int N_LO = 32
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic init,
    input logic ld,
    input logic mod,
    input logic div
);

    logic [7:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_q <= '0;
        else if (tick)
            gap_q <= '0;
        else if (gap_q != 8'hFF)
            gap_q <= gap_q + 8'd1;
    end

    // R1
    min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q >= 8'(N_LO - 1)));

    // R2
    mod_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod) |-> ($past(tick) || $past(init)));

    // R4
    mod_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod) |-> $past(ld));

    // R5
    ld_to_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> div);

    // R5
    div_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div |=> !div);

    // R7
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!div && !ld && !mod);
        end
    end

endmodule

bind swallow_divider swdiv_chk #(.N_LO(N_LO)) u_chk (
    .clk   (clk_in),
    .rst_n (rst_n),
    .tick  (tick),
    .init  (init),
    .ld    (ld_o),
    .mod   (mod_o),
    .div   (div_out)
);

// File: tb/test_swallow_divider.sv
`timescale 1ns/1ps
module test_swallow_divider;

    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic       band_hi = 1'b0;
    logic [6:0] p_load = 7'd2;
    logic [5:0] s_load = 6'd1;
    logic       div_out;
    logic       mod_o;
    logic       ld_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk_in = ~clk_in;

    swallow_divider i_swallow_divider (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .band_hi (band_hi),
        .p_load  (p_load),
        .s_load  (s_load),
        .div_out (div_out),
        .mod_o   (mod_o),
        .ld_o    (ld_o)
    );

    always @(posedge clk_in) begin
        cyc++;
        if (cyc == 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Precondition: at a negedge with ld_o high. Applies the configuration,
    // measures one full period and ends at its ld_o cycle.
    task automatic run_frame(input bit band, input int p, input int s,
                             input bit mid, input bit mband, input int mp, input int ms);
        int n;
        int cnt;
        int mz;
        int extra;
        int back;
        bit prev_mod;
        n = band ? 47 : 32;
        band_hi = band;
        p_load  = 7'(p);
        s_load  = 6'(s);
        @(negedge clk_in);
        chk(div_out == 1'b1, "R5 div_out after ld_o", int'(div_out), 1);
        chk(ld_o == 1'b0, "R5 ld_o single cycle", int'(ld_o), 0);
        cnt = 1;
        mz = mod_o ? 0 : 1;
        extra = 0;
        back = 0;
        prev_mod = mod_o;
        while (1) begin
            @(negedge clk_in);
            if (mid && cnt == 200) begin
                band_hi = mband;
                p_load  = 7'(mp);
                s_load  = 6'(ms);
            end
            cnt++;
            if (!mod_o) mz++;
            if (prev_mod && !mod_o) back++;
            prev_mod = mod_o;
            if (div_out) extra++;
            if (ld_o) break;
        end
        if (mid)
            chk(cnt == n * p + s, "R6 mid-period change ignored", cnt, n * p + s);
        else
            chk(cnt == n * p + s, "R1 period length", cnt, n * p + s);
        if (s == 0)
            chk(mz == 0, "R3 S=0 mod high all period", mz, 0);
        else
            chk(mz == s * (n + 1), "R2 swallow phase length", mz, s * (n + 1));
        chk(back == 0, "R4 mod falls only at reload", back, 0);
        chk(extra == 0, "R5 one div_out per period", extra, 0);
    endtask

    initial begin
        int waited;
        int lo_s[4];
        int hi_s[4];
        int hi_p[3];
        lo_s = '{0, 1, 16, 31};
        hi_s = '{0, 1, 24, 47};
        hi_p = '{105, 114, 122};

        repeat (4) @(negedge clk_in);
        chk(div_out == 1'b0, "R7 reset div_out", int'(div_out), 0);
        chk(ld_o == 1'b0, "R7 reset ld_o", int'(ld_o), 0);
        chk(mod_o == 1'b0, "R7 reset mod_o", int'(mod_o), 0);
        rst_n = 1'b1;
        @(negedge clk_in);
        chk(mod_o == 1'b0, "R7 first config loaded (S=1 swallow)", int'(mod_o), 0);
        waited = 0;
        while (!ld_o) begin
            @(negedge clk_in);
            waited++;
        end
        chk(waited == 64, "R7 first period 32*2+1", waited + 1, 65);

        // low band sweep
        for (int p = 75; p <= 78; p++)
            for (int i = 0; i < 4; i++)
                run_frame(1'b0, p, lo_s[i], 1'b0, 1'b0, 0, 0);

        // high band sweep
        for (int j = 0; j < 3; j++)
            for (int i = 0; i < 4; i++)
                run_frame(1'b1, hi_p[j], hi_s[i], 1'b0, 1'b0, 0, 0);

        // boundaries
        run_frame(1'b0, 1, 0, 1'b0, 1'b0, 0, 0);
        run_frame(1'b1, 1, 1, 1'b0, 1'b0, 0, 0);
        run_frame(1'b0, 3, 3, 1'b0, 1'b0, 0, 0);
        run_frame(1'b1, 47, 47, 1'b0, 1'b0, 0, 0);
        run_frame(1'b0, 127, 0, 1'b0, 1'b0, 0, 0);

        // mid-period change: current period keeps old values, next uses new
        run_frame(1'b0, 76, 10, 1'b1, 1'b1, 110, 5);
        run_frame(1'b1, 110, 5, 1'b0, 1'b0, 0, 0);
        run_frame(1'b1, 106, 40, 1'b1, 1'b0, 77, 0);
        run_frame(1'b0, 77, 0, 1'b0, 1'b0, 0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule